// File: doc/BRIEF.md
# Hashed MAC Address Table Engine

The engine keeps a forwarding database of {VLAN ID, MAC address, destination port} entries in a table of 2048 rows. Each row has four buckets. An entry always lives in the row given by a fixed 11-bit XOR fold of the low six VID bits and the 48-bit MAC. When software asks the engine to learn an entry, the engine picks the bucket itself. Software therefore only loads the key and issues a command.

A host reaches the engine through four 32-bit registers: a key-high word, a key-low word, an index word and a command/status word. The host writes the key and then writes a command. It then polls the command field, or the `busy` output, until the engine is idle again. Three commands exist:

- Learn places the entry in the first free bucket of the hashed row.
- Forget invalidates the matching entry in the hashed row.
- Read returns one bucket of the row named in the index register.

A read with the snapshot flag set captures the whole row into a shadow buffer. Reads without the flag are served from that buffer, so a full row can be walked with one memory access.

Top module: `mac_table_engine`

## Requirements
- R1: After reset `busy` stays high for exactly 2048 cycles while every row is cleared, counted from the first low-reset cycle. Afterwards every register reads zero and every bucket reads invalid.
- R2: Learn and forget act on row = {1'b0, VID[5:0], MAC[47:44]} ^ MAC[43:33] ^ MAC[32:22] ^ MAC[21:11] ^ MAC[10:0]. The VID and MAC come from the key registers.
- R3: Register map and readback:
  - Address 0 (key high): VID in bits 27:16, MAC[47:32] in bits 15:0, bits 31:28 read zero.
  - Address 1 (key low): MAC[31:0].
  - Address 2 (index): snapshot flag in bit 13, bucket in bits 12:11, row in bits 10:0, upper bits read zero.
  - Address 3 (command/status): command in bits 1:0, valid in bit 2, locked in bit 3, port in bits 6:4, overflow in bit 8, not-found in bit 9.
- R4: The command codes are 00 idle, 01 learn, 10 forget and 11 read. Writing address 3 with a non-zero code starts that command. Learn stores the entry in the lowest-numbered invalid bucket of its row, so successive colliding entries fill buckets 0, 1, 2, 3 in order.
- R5: A learn into a row whose four buckets are all valid writes nothing and sets the overflow bit. The overflow bit clears when the next command is accepted.
- R6: Forget clears the valid flag of the bucket whose VID and MAC both match the key. If no bucket matches, the row is unchanged and the not-found bit is set until the next command.
- R7: After a forget, a learn into the same row reuses the freed bucket.
- R8: A read with the snapshot flag captures the row and returns the selected bucket. A read without the flag returns the selected bucket of the last snapshot, even if the table has changed since.
- R9: Learn and forget keep `busy` high, with the command field at its code, for exactly 6 cycles after the accepting edge. A read keeps them for exactly 2 cycles. The command field then returns to 00.
- R10: Register writes, including new commands, are ignored while `busy` is high.
- R11: A read of an invalid bucket returns valid 0, locked 0, port 0 and zero VID and MAC.
- R12: A learned entry stores valid = 1, together with the locked bit and the port taken from the learn command word. A read returns them in bits 2, 3 and 6:4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data, combinational from rd_addr |
| busy | output | 1 | High while clearing after reset or executing a command |

## Verification
The hardest state to reach is a snapshot that disagrees with the live table. To get there, the bench captures a full row with a snapshot read and then forgets one of its entries. A following flagless read must still show the forgotten entry, and a fresh snapshot must show it invalid. Full rows are built by choosing MACs whose low two 11-bit slices differ by the same XOR delta, so all of them hash to one row. That row is then driven into overflow and has buckets freed and refilled. Finally a forget is issued, and a key write and a learn are queued inside its busy window; the queued learn, had it been taken, would visibly refill the bucket.

// File: rtl/mt_pkg.sv
package mt_pkg;
    localparam int ROW_W   = 11;
    localparam int ROWS    = 1 << ROW_W;
    localparam int NBKT    = 4;
    localparam int BKT_W   = $clog2(NBKT);
    localparam int PORT_W  = 3;
    localparam int VID_W   = 12;
    localparam int MAC_W   = 48;
    localparam int HVID_W  = 6;
    localparam int REG_W   = 32;

    localparam logic [1:0] ADDR_KEYHI = 2'd0;
    localparam logic [1:0] ADDR_KEYLO = 2'd1;
    localparam logic [1:0] ADDR_INDEX = 2'd2;
    localparam logic [1:0] ADDR_CMD   = 2'd3;

    typedef enum logic [1:0] {
        CMD_IDLE   = 2'b00,
        CMD_LEARN  = 2'b01,
        CMD_FORGET = 2'b10,
        CMD_READ   = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        S_INIT, S_IDLE, S_FETCH, S_SCAN, S_WB, S_RDOUT
    } state_e;

    typedef struct packed {
        logic              valid;
        logic              locked;
        logic [PORT_W-1:0] port;
        logic [VID_W-1:0]  vid;
        logic [MAC_W-1:0]  mac;
    } entry_t;

    typedef entry_t [NBKT-1:0] row_t;

    localparam int ROW_BITS = $bits(row_t);
endpackage

// File: rtl/mt_hash.sv
module mt_hash
    import mt_pkg::*;
(
    input  logic [HVID_W-1:0] vid_lo,
    input  logic [MAC_W-1:0]  mac,
    output logic [ROW_W-1:0]  row
);
    localparam int KEY_W = ROW_W * ((HVID_W + MAC_W + ROW_W - 1) / ROW_W);
    localparam int FOLDS = KEY_W / ROW_W;
    localparam int PAD_W = KEY_W - HVID_W - MAC_W;

    logic [KEY_W-1:0] key;
    assign key = {{PAD_W{1'b0}}, vid_lo, mac};

    always_comb begin
        row = '0;
        for (int i = 0; i < FOLDS; i++) begin
            row = row ^ key[i*ROW_W +: ROW_W];
        end
    end
endmodule

// File: rtl/mt_row_ram.sv
module mt_row_ram #(
    parameter int AW = 11,
    parameter int DW = 260
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/mac_table_engine.sv
module mac_table_engine
    import mt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             busy
);
    state_e            state;
    cmd_e              cmd_q;
    logic [VID_W-1:0]  vid_q;
    logic [MAC_W-1:0]  mac_q;
    logic              snap_req_q;
    logic [BKT_W-1:0]  bkt_q;
    logic [ROW_W-1:0]  idx_row_q;
    logic              st_valid, st_locked;
    logic [PORT_W-1:0] st_port;
    logic              ovf_q, nf_q;
    logic [ROW_W-1:0]  op_row_q, init_row, hash_row;
    logic [BKT_W-1:0]  scan_k, hit_q;
    logic              found_q;
    row_t              shadow_q, ram_q, wrow, rsrc;
    entry_t            scan_e, pick_e;
    logic              ram_we, host_ok, start, scan_hit;
    logic [ROW_W-1:0]  ram_waddr;
    logic [ROW_BITS-1:0] ram_wdata, ram_rdata;

    mt_hash i_hash (
        .vid_lo (vid_q[HVID_W-1:0]),
        .mac    (mac_q),
        .row    (hash_row)
    );

    mt_row_ram #(.AW(ROW_W), .DW(ROW_BITS)) i_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (op_row_q),
        .rdata (ram_rdata)
    );

    assign ram_q   = row_t'(ram_rdata);
    assign busy    = (state != S_IDLE);
    assign host_ok = wr_en && (state == S_IDLE);
    assign start   = host_ok && (wr_addr == ADDR_CMD) && (wr_data[1:0] != CMD_IDLE);

    always_comb begin
        scan_e = ram_q[scan_k];
        if (cmd_q == CMD_LEARN) begin
            scan_hit = !scan_e.valid;
        end else begin
            scan_hit = scan_e.valid && (scan_e.vid == vid_q) && (scan_e.mac == mac_q);
        end
    end

    always_comb begin
        wrow = ram_q;
        if (cmd_q == CMD_LEARN) begin
            wrow[hit_q] = '{valid: 1'b1, locked: st_locked, port: st_port,
                            vid: vid_q, mac: mac_q};
        end else begin
            wrow[hit_q].valid = 1'b0;
        end
    end

    assign ram_we    = (state == S_INIT) || ((state == S_WB) && found_q);
    assign ram_waddr = (state == S_INIT) ? init_row : op_row_q;
    assign ram_wdata = (state == S_INIT) ? '0 : ROW_BITS'(wrow);

    assign rsrc   = snap_req_q ? ram_q : shadow_q;
    assign pick_e = rsrc[bkt_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_INIT;
            init_row   <= '0;
            cmd_q      <= CMD_IDLE;
            vid_q      <= '0;
            mac_q      <= '0;
            snap_req_q <= 1'b0;
            bkt_q      <= '0;
            idx_row_q  <= '0;
            st_valid   <= 1'b0;
            st_locked  <= 1'b0;
            st_port    <= '0;
            ovf_q      <= 1'b0;
            nf_q       <= 1'b0;
            op_row_q   <= '0;
            scan_k     <= '0;
            hit_q      <= '0;
            found_q    <= 1'b0;
            shadow_q   <= '0;
        end else begin
            case (state)
                S_INIT: begin
                    init_row <= init_row + 1'b1;
                    if (init_row == ROW_W'(ROWS - 1)) begin
                        state <= S_IDLE;
                    end
                end
                S_IDLE: begin
                    if (host_ok) begin
                        case (wr_addr)
                            ADDR_KEYHI: begin
                                vid_q             <= wr_data[16 +: VID_W];
                                mac_q[MAC_W-1:32] <= wr_data[15:0];
                            end
                            ADDR_KEYLO: mac_q[31:0] <= wr_data;
                            ADDR_INDEX: begin
                                snap_req_q <= wr_data[ROW_W + BKT_W];
                                bkt_q      <= wr_data[ROW_W +: BKT_W];
                                idx_row_q  <= wr_data[ROW_W-1:0];
                            end
                            default: begin
                                st_valid  <= wr_data[2];
                                st_locked <= wr_data[3];
                                st_port   <= wr_data[4 +: PORT_W];
                            end
                        endcase
                    end
                    if (start) begin
                        cmd_q    <= cmd_e'(wr_data[1:0]);
                        ovf_q    <= 1'b0;
                        nf_q     <= 1'b0;
                        op_row_q <= (wr_data[1:0] == CMD_READ) ? idx_row_q : hash_row;
                        scan_k   <= '0;
                        found_q  <= 1'b0;
                        state    <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    state <= (cmd_q == CMD_READ) ? S_RDOUT : S_SCAN;
                end
                S_SCAN: begin
                    if (!found_q && scan_hit) begin
                        found_q <= 1'b1;
                        hit_q   <= scan_k;
                    end
                    if (scan_k == BKT_W'(NBKT - 1)) begin
                        state <= S_WB;
                    end else begin
                        scan_k <= scan_k + 1'b1;
                    end
                end
                S_WB: begin
                    if (!found_q) begin
                        if (cmd_q == CMD_LEARN) ovf_q <= 1'b1;
                        else                    nf_q  <= 1'b1;
                    end
                    cmd_q <= CMD_IDLE;
                    state <= S_IDLE;
                end
                default: begin
                    if (snap_req_q) begin
                        shadow_q <= ram_q;
                    end
                    st_valid  <= pick_e.valid;
                    st_locked <= pick_e.valid && pick_e.locked;
                    st_port   <= pick_e.valid ? pick_e.port : '0;
                    vid_q     <= pick_e.valid ? pick_e.vid : '0;
                    mac_q     <= pick_e.valid ? pick_e.mac : '0;
                    cmd_q     <= CMD_IDLE;
                    state     <= S_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_KEYHI: rd_data = {4'b0, vid_q, mac_q[MAC_W-1:32]};
            ADDR_KEYLO: rd_data = mac_q[31:0];
            ADDR_INDEX: rd_data = REG_W'({snap_req_q, bkt_q, idx_row_q});
            default:    rd_data = REG_W'({nf_q, ovf_q, 1'b0, st_port, st_locked,
                                          st_valid, cmd_q});
        endcase
    end

    // R9: an accepted command raises busy and enters the fetch step
    a_r9_start_busy: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && state == S_FETCH && cmd_q != CMD_IDLE));

    // R1: the idle state always shows an idle command field
    a_r1_idle_cmd: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) |-> (cmd_q == CMD_IDLE));

    // R10: while an operation is in flight, the host-written registers hold
    a_r10_hold_regs: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH || state == S_SCAN || state == S_WB) |=>
        ($stable(vid_q) && $stable(mac_q) && $stable(idx_row_q) && $stable(bkt_q)));

    // R5: a learn write-back only targets a bucket that was free
    a_r5_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        (state == S_WB && cmd_q == CMD_LEARN && ram_we) |-> !ram_q[hit_q].valid);

    // R6: a forget write-back only targets a bucket matching the key
    a_r6_forget_match: assert property (@(posedge clk) disable iff (rst)
        (state == S_WB && cmd_q == CMD_FORGET && ram_we) |->
        (ram_q[hit_q].valid && ram_q[hit_q].vid == vid_q && ram_q[hit_q].mac == mac_q));

    // R5, R6: sticky status bits belong to one command at a time
    a_r6_flags_excl: assert property (@(posedge clk) disable iff (rst)
        !(ovf_q && nf_q));
endmodule

// File: tb/test_mac_table_engine.sv
module test_mac_table_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        busy;

    int total = 0;
    int bad = 0;
    int cnt [2048];

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_table_engine i_mac_table_engine (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    function automatic logic [10:0] bhash(logic [11:0] v, logic [47:0] m);
        return {1'b0, v[5:0], m[47:44]} ^ m[43:33] ^ m[32:22] ^ m[21:11] ^ m[10:0];
    endfunction

    task automatic chk(string tag, logic [95:0] got, logic [95:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic host_wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_rd(logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_cmd(logic [31:0] v, output int n);
        host_wr(2'd3, v);
        wait_idle(n);
    endtask

    task automatic set_key(logic [11:0] v, logic [47:0] m);
        host_wr(2'd0, {4'b0, v, m[47:32]});
        host_wr(2'd1, m[31:0]);
    endtask

    task automatic learn(logic [11:0] v, logic [47:0] m, logic [2:0] p, logic lk,
                         output int n);
        set_key(v, m);
        do_cmd({25'b0, p, lk, 1'b0, 2'b01}, n);
    endtask

    task automatic forget(logic [11:0] v, logic [47:0] m, output int n);
        set_key(v, m);
        do_cmd(32'h2, n);
    endtask

    task automatic read_bkt(logic [10:0] row, logic [1:0] b, logic snap,
                            output logic [95:0] res, output int n);
        logic [31:0] st, hi, lo;
        host_wr(2'd2, {18'b0, snap, b, row});
        do_cmd(32'h3, n);
        host_rd(2'd3, st);
        host_rd(2'd0, hi);
        host_rd(2'd1, lo);
        res = {st, hi, lo};
    endtask

    function automatic logic [95:0] exp_ent(logic vld, logic [11:0] v, logic [47:0] m,
                                            logic [2:0] p, logic lk);
        if (!vld) return '0;
        return {25'b0, p, lk, 1'b1, 2'b00, 4'b0, v, m[47:32], m[31:0]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [95:0] r;
        int n;
        logic [11:0] cv;
        logic [47:0] cm [6];
        logic [10:0] crow;

        for (int i = 0; i < 2048; i++) cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: clearing sweep length
        wait_idle(n);
        chk("R1 init busy cycles", 96'(n), 96'(2048));
        for (int a = 0; a < 4; a++) begin
            host_rd(2'(a), d);
            chk("R1 register zero after reset", 96'(d), 96'(0));
        end
        read_bkt(11'h5A5, 2'd3, 1'b1, r, n);
        chk("R1 bucket invalid after init", r, '0);

        // R3: readback masks
        host_wr(2'd0, 32'hFFFF_FFFF);
        host_rd(2'd0, d);
        chk("R3 key high mask", 96'(d), 96'(32'h0FFF_FFFF));
        host_wr(2'd1, 32'hDEAD_BEEF);
        host_rd(2'd1, d);
        chk("R3 key low", 96'(d), 96'(32'hDEAD_BEEF));
        host_wr(2'd2, 32'hFFFF_FFFF);
        host_rd(2'd2, d);
        chk("R3 index mask", 96'(d), 96'(32'h3FFF));
        host_wr(2'd3, 32'hFFFF_FFFC);
        host_rd(2'd3, d);
        chk("R3 status fields", 96'(d), 96'(32'h7C));
        chk("R3 no command started", 96'(busy), 96'(0));

        // colliding key set: equal XOR delta in the two low slices
        cv = 12'h123;
        for (int k = 0; k < 6; k++) begin
            cm[k] = 48'hA55A_C33C_0FF0 ^ ((48'(k + 1) << 11) | 48'(k + 1));
        end
        crow = bhash(cv, cm[0]);
        for (int k = 1; k < 6; k++) begin
            chk("R2 collision set shares row", 96'(bhash(cv, cm[k])), 96'(crow));
        end

        // R4, R9, R12: fill the row
        learn(cv, cm[0], 3'd1, 1'b1, n);
        chk("R9 learn busy cycles", 96'(n), 96'(6));
        learn(cv, cm[1], 3'd2, 1'b0, n);
        learn(cv, cm[2], 3'd3, 1'b1, n);
        learn(cv, cm[3], 3'd4, 1'b0, n);
        read_bkt(crow, 2'd0, 1'b1, r, n);
        chk("R9 read busy cycles", 96'(n), 96'(2));
        chk("R4 bucket 0 R12 fields", r, exp_ent(1, cv, cm[0], 3'd1, 1'b1));
        read_bkt(crow, 2'd1, 1'b0, r, n);
        chk("R4 bucket 1", r, exp_ent(1, cv, cm[1], 3'd2, 1'b0));
        read_bkt(crow, 2'd2, 1'b0, r, n);
        chk("R4 bucket 2", r, exp_ent(1, cv, cm[2], 3'd3, 1'b1));
        read_bkt(crow, 2'd3, 1'b0, r, n);
        chk("R4 bucket 3", r, exp_ent(1, cv, cm[3], 3'd4, 1'b0));

        // R5: overflow
        learn(cv, cm[4], 3'd5, 1'b0, n);
        host_rd(2'd3, d);
        chk("R5 overflow set", 96'(d[9:8]), 96'(2'b01));
        for (int b = 0; b < 4; b++) begin
            read_bkt(crow, 2'(b), 1'b1, r, n);
            chk("R5 row unchanged on overflow", 96'(r[95:64] & 32'h7C), 96'(32'h4 | (32'(b + 1) << 4) | ((b % 2 == 0) ? 32'h8 : 32'h0)));
            chk("R5 overflow cleared by next command", 96'(r[73:72]), 96'(0));
        end

        // R8: snapshot survives a forget; R6
        read_bkt(crow, 2'd0, 1'b1, r, n);
        forget(cv, cm[2], n);
        chk("R9 forget busy cycles", 96'(n), 96'(6));
        host_rd(2'd3, d);
        chk("R6 forget found", 96'(d[9:8]), 96'(0));
        read_bkt(crow, 2'd2, 1'b0, r, n);
        chk("R8 snapshot holds old entry", r, exp_ent(1, cv, cm[2], 3'd3, 1'b1));
        read_bkt(crow, 2'd0, 1'b1, r, n);
        chk("R8 new snapshot bucket 0", r, exp_ent(1, cv, cm[0], 3'd1, 1'b1));
        read_bkt(crow, 2'd2, 1'b0, r, n);
        chk("R6 R11 forgotten bucket zero", r, '0);

        // R6: forget of absent key
        forget(cv, cm[5], n);
        host_rd(2'd3, d);
        chk("R6 not found set", 96'(d[9:8]), 96'(2'b10));
        read_bkt(crow, 2'd1, 1'b1, r, n);
        chk("R6 row unchanged on miss", r, exp_ent(1, cv, cm[1], 3'd2, 1'b0));
        chk("R6 not found cleared", 96'(r[73:72]), 96'(0));

        // R7: refill freed bucket
        learn(cv, cm[4], 3'd6, 1'b1, n);
        host_rd(2'd3, d);
        chk("R7 no overflow on refill", 96'(d[9:8]), 96'(0));
        read_bkt(crow, 2'd2, 1'b1, r, n);
        chk("R7 freed bucket reused", r, exp_ent(1, cv, cm[4], 3'd6, 1'b1));

        // R10: writes during busy are dropped
        set_key(cv, cm[0]);
        host_wr(2'd3, 32'h2);
        host_wr(2'd0, 32'h0ABC_DEF1);
        host_wr(2'd3, 32'h1);
        wait_idle(n);
        host_rd(2'd0, d);
        chk("R10 key high unchanged", 96'(d), 96'({4'b0, cv, cm[0][47:32]}));
        host_rd(2'd3, d);
        chk("R10 status not rewritten", 96'(d), 96'(0));
        read_bkt(crow, 2'd0, 1'b1, r, n);
        chk("R10 queued learn dropped", r, '0);
        learn(cv, cm[0], 3'd1, 1'b1, n);
        read_bkt(crow, 2'd0, 1'b1, r, n);
        chk("R7 bucket 0 refilled", r, exp_ent(1, cv, cm[0], 3'd1, 1'b1));
        cnt[crow] = 4;

        // R2: hash sweep across many keys
        for (int i = 0; i < 48; i++) begin
            logic [11:0] v;
            logic [47:0] m;
            logic [10:0] row;
            v = 12'(i * 41 + 7);
            m = {8'(i * 29 + 3), 8'(i * 71), 8'(i * 13 + 5),
                 8'(i * 97), 8'(i * 3), 8'(i * 151 + 1)};
            row = bhash(v, m);
            learn(v, m, 3'(i), 1'(i), n);
            host_rd(2'd3, d);
            if (cnt[row] < 4) begin
                chk("R2 learn accepted", 96'(d[8]), 96'(0));
                read_bkt(row, 2'(cnt[row]), 1'b1, r, n);
                chk("R2 entry in hashed row", r, exp_ent(1, v, m, 3'(i), 1'(i)));
                cnt[row]++;
            end else begin
                chk("R2 R5 full row overflow", 96'(d[8]), 96'(1));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule